// File: doc/BRIEF.md
# Static Memory Burst Write Sequencer

The sequencer turns one internal write request into a burst of two to four write beats on an external static memory port. A request carries a start address, up to four data words, a transfer size (halfword or word), a programmed beat count, a programmed wait-state count and a flag that says whether the memory is written through the write-enable strobe. The sequencer takes a request only while idle. It then drives chip select low for the whole burst, pulses write enable once per beat, keeps output enable high, and steps the address after each completed beat.

Each beat lasts one clock plus the programmed wait states. The beat is stretched further while the external ready input is low. Ready is captured on the falling clock edge and then passed through a second flop on the rising edge before it is used. When the write-enable strobe is in use, a programmed count of zero wait states is raised to one, because a one-clock strobe cannot meet the memory's timing. Once the burst ends, address, data, size qualifiers and the write indication keep their last values until the next burst starts. A one-clock done pulse marks the end of the burst.

Top module: `sram_burst_writer`

## Requirements
- R1: While reset is held and right after it, memCsN, memWeN and memOeN are high, idle is 1, done is 0 and memWrite is 0.
- R2: A request (reqValid high at a rising edge) is accepted only when idle is 1. A request raised during a burst changes nothing in that burst and starts no burst after it. idle is 0 for every cycle of a burst.
- R3: The number of beats is cfgBeats clamped to the range 2 to 4. Values 0 and 1 give 2 beats, and values 5 to 7 give 4 beats.
- R4: While ready is high, each beat lasts exactly 1 + W clocks. W is cfgWait, except that W is 1 when cfgUseWe is 1 and cfgWait is 0.
- R5: A beat finishes only in a clock whose synchronized ready is high. memRdy is sampled on the falling edge of clock k and can let a beat finish at the end of clock k+1 at the earliest. If it is low, the final clock of the beat repeats.
- R6: During beat i, memAddr is the start address plus 2*i when reqWord is 0 (halfword) or plus 4*i when reqWord is 1 (word). memData is data word i, taken from reqData bits [32*i+31 : 32*i]. memWord equals reqWord and memHalf equals its inverse.
- R7: memCsN is low from the first clock of beat 0 through the final clock of the last beat, and high in every other clock.
- R8: When cfgUseWe is 1, memWeN is low in every clock of the burst except the final clock of each beat, where it is high. When cfgUseWe is 0, memWeN stays high.
- R9: memOeN is high at all times.
- R10: done is high for exactly the one clock after the last beat finishes, and memCsN is already high in that clock.
- R11: After a burst, memAddr, memData, memHalf, memWord and memWrite=1 hold their last values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Burst request |
| reqAddr | input | ADDR_W | Start address |
| reqWord | input | 1 | Size: 1 word, 0 halfword |
| reqData | input | 4*DATA_W | Data words, word i at bits [DATA_W*i +: DATA_W] |
| cfgBeats | input | 3 | Programmed beat count (clamped to 2..4) |
| cfgWait | input | WAIT_W | Programmed wait states per beat |
| cfgUseWe | input | 1 | Memory is written through the write-enable strobe |
| memRdy | input | 1 | External ready, asynchronous |
| idle | output | 1 | Sequencer idle, request can be taken |
| done | output | 1 | One-clock end-of-burst pulse |
| memCsN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low, held high |
| memAddr | output | ADDR_W | Memory address |
| memData | output | DATA_W | Write data |
| memHalf | output | 1 | Halfword size qualifier |
| memWord | output | 1 | Word size qualifier |
| memWrite | output | 1 | Write indication |

## Verification
The assertions assume that requests and configuration change only between clock edges and that cfgWait fits in its field. They also assume that ready can stall a beat but never ends a burst early. The bench drives every input one nanosecond after a rising edge, including memRdy, so the falling-edge capture always sees a settled value. Random memRdy patterns, random beat counts and random wait counts stay inside the field widths. The request is raised only while the sequencer is idle, except in the deliberate mid-burst request, which is withdrawn before the done clock.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int MAX_BEATS = 4;
  localparam int MIN_BEATS = 2;
  localparam int BEAT_W    = $clog2(MAX_BEATS);

  typedef struct packed {
    logic load;     // capture a new request
    logic advance;  // step to the next beat
  } sbwStrobe_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } sbwState_t;
endpackage

// File: rtl/sbw_rdy_sync.sv
module sbw_rdy_sync (
  input  logic clk,
  input  logic rstN,
  input  logic rdyAsync,
  output logic rdySync
);
  logic rdyFall;

  // first stage on the falling edge: ready is looked at half a clock before use
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) rdyFall <= 1'b0;
    else       rdyFall <= rdyAsync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdySync <= 1'b0;
    else       rdySync <= rdyFall;
  end
endmodule

// File: rtl/sbw_ctrl.sv
module sbw_ctrl
  import sbw_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        cfgBeats,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              cfgUseWe,
  input  logic              rdySync,
  output sbwStrobe_t        strobe,
  output logic              csN,
  output logic              weN,
  output logic              idle,
  output logic              done
);
  sbwState_t         state;
  logic [BEAT_W-1:0] beatIdx;
  logic [BEAT_W-1:0] lastIdx;
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitEff;
  logic              useWe;

  logic              accept;
  logic              beatEnd;
  logic [BEAT_W-1:0] lastIdxReq;
  logic [WAIT_W-1:0] waitReq;

  always_comb begin
    if (cfgBeats < 3'(MIN_BEATS))      lastIdxReq = BEAT_W'(MIN_BEATS - 1);
    else if (cfgBeats > 3'(MAX_BEATS)) lastIdxReq = BEAT_W'(MAX_BEATS - 1);
    else                               lastIdxReq = BEAT_W'(cfgBeats - 3'd1);
  end

  // a one-clock write-enable pulse is not allowed: raise zero waits to one
  assign waitReq = (cfgUseWe && cfgWait == '0) ? WAIT_W'(1) : cfgWait;

  assign accept  = (state == ST_IDLE) && reqValid;
  assign beatEnd = (state == ST_BURST) && (waitCnt == '0) && rdySync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatIdx <= '0;
      lastIdx <= '0;
      waitCnt <= '0;
      waitEff <= '0;
      useWe   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_BURST;
            beatIdx <= '0;
            lastIdx <= lastIdxReq;
            waitEff <= waitReq;
            waitCnt <= waitReq;
            useWe   <= cfgUseWe;
          end
        end
        ST_BURST: begin
          if (beatEnd) begin
            if (beatIdx == lastIdx) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              beatIdx <= beatIdx + 1'b1;
              waitCnt <= waitEff;
            end
          end else if (waitCnt != '0) begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.load    = accept;
  assign strobe.advance = beatEnd && (beatIdx != lastIdx);

  assign csN  = (state != ST_BURST);
  assign weN  = !((state == ST_BURST) && useWe && !beatEnd);
  assign idle = (state == ST_IDLE);
endmodule

// File: rtl/sbw_datapath.sv
module sbw_datapath
  import sbw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  sbwStrobe_t                  strobe,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic                        reqWord,
  input  logic [MAX_BEATS*DATA_W-1:0] reqData,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [DATA_W-1:0]           memData,
  output logic                        memHalf,
  output logic                        memWord,
  output logic                        memWrite
);
  logic [DATA_W-1:0] wordBuf [MAX_BEATS];
  logic [BEAT_W-1:0] idx;
  logic              sizeWord;
  logic [ADDR_W-1:0] addrStep;

  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_buf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            wordBuf[g] <= '0;
      else if (strobe.load) wordBuf[g] <= reqData[g*DATA_W +: DATA_W];
    end
  end

  assign addrStep = sizeWord ? ADDR_W'(4) : ADDR_W'(2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      idx      <= '0;
      sizeWord <= 1'b0;
      memHalf  <= 1'b0;
      memWrite <= 1'b0;
    end else if (strobe.load) begin
      memAddr  <= reqAddr;
      idx      <= '0;
      sizeWord <= reqWord;
      memHalf  <= !reqWord;
      memWrite <= 1'b1;
    end else if (strobe.advance) begin
      memAddr <= memAddr + addrStep;
      idx     <= idx + 1'b1;
    end
  end

  assign memWord = sizeWord;
  assign memData = wordBuf[idx];
endmodule

// File: rtl/sram_burst_writer.sv
module sram_burst_writer
  import sbw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic                        reqWord,
  input  logic [MAX_BEATS*DATA_W-1:0] reqData,
  input  logic [2:0]                  cfgBeats,
  input  logic [WAIT_W-1:0]           cfgWait,
  input  logic                        cfgUseWe,
  input  logic                        memRdy,
  output logic                        idle,
  output logic                        done,
  output logic                        memCsN,
  output logic                        memWeN,
  output logic                        memOeN,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [DATA_W-1:0]           memData,
  output logic                        memHalf,
  output logic                        memWord,
  output logic                        memWrite
);
  sbwStrobe_t strobe;
  logic       rdySync;

  sbw_rdy_sync i_sync (
    .clk      (clk),
    .rstN     (rstN),
    .rdyAsync (memRdy),
    .rdySync  (rdySync)
  );

  sbw_ctrl #(.WAIT_W(WAIT_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cfgBeats (cfgBeats),
    .cfgWait  (cfgWait),
    .cfgUseWe (cfgUseWe),
    .rdySync  (rdySync),
    .strobe   (strobe),
    .csN      (memCsN),
    .weN      (memWeN),
    .idle     (idle),
    .done     (done)
  );

  sbw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWord  (reqWord),
    .reqData  (reqData),
    .memAddr  (memAddr),
    .memData  (memData),
    .memHalf  (memHalf),
    .memWord  (memWord),
    .memWrite (memWrite)
  );

  assign memOeN = 1'b1;
endmodule

// File: rtl/sbw_checker.sv
module sbw_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              idle,
  input logic              done,
  input logic              memCsN,
  input logic              memWeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memData,
  input logic              memWord
);
  // R2: a burst starts only after a request seen while idle
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCsN) |-> $past(reqValid && idle));

  // R10: done lasts one clock
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: done follows the final burst clock, with chip select already released
  p_done_after_cs_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (memCsN && $past(!memCsN)));

  // R8: write enable only inside chip select
  p_we_in_cs_r8: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCsN);

  // R8: a rising write enable inside a burst marks a finished beat
  p_we_rise_beat_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memWeN) && !memCsN) |=> (done || memAddr != $past(memAddr)));

  // R6: within a burst the address steps by the transfer size
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN) && memAddr != $past(memAddr)) |->
      (memAddr - $past(memAddr) == (memWord ? ADDR_W'(4) : ADDR_W'(2))));

  // R11: outputs hold while idle
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (idle && $past(idle)) |-> ($stable(memAddr) && $stable(memData)));
endmodule

bind sram_burst_writer sbw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sbwChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .idle     (idle),
  .done     (done),
  .memCsN   (memCsN),
  .memWeN   (memWeN),
  .memAddr  (memAddr),
  .memData  (memData),
  .memWord  (memWord)
);

// File: tb/test_sram_burst_writer.sv
`timescale 1ns/1ps
module test_sram_burst_writer;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam int WW = 3;
  localparam int NB = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic [AW-1:0]   reqAddr = '0;
  logic            reqWord = 1'b0;
  logic [NB*DW-1:0] reqData = '0;
  logic [2:0]      cfgBeats = 3'd2;
  logic [WW-1:0]   cfgWait = '0;
  logic            cfgUseWe = 1'b0;
  logic            memRdy = 1'b1;
  logic            idle, done, memCsN, memWeN, memOeN, memHalf, memWord, memWrite;
  logic [AW-1:0]   memAddr;
  logic [DW-1:0]   memData;

  int nChecks = 0;
  int nFails  = 0;
  bit rdyPrev = 1'b1;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sram_burst_writer #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) i_sram_burst_writer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqWord(reqWord),
    .reqData(reqData), .cfgBeats(cfgBeats), .cfgWait(cfgWait), .cfgUseWe(cfgUseWe),
    .memRdy(memRdy), .idle(idle), .done(done), .memCsN(memCsN), .memWeN(memWeN),
    .memOeN(memOeN), .memAddr(memAddr), .memData(memData), .memHalf(memHalf),
    .memWord(memWord), .memWrite(memWrite)
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int effBeats(input logic [2:0] b);
    if (b < 3'd2) return 2;
    if (b > 3'd4) return 4;
    return int'(b);
  endfunction

  function automatic int effWait(input logic [WW-1:0] w, input bit useWe);
    if (useWe && w == '0) return 1;
    return int'(w);
  endfunction

  task automatic driveRdy(input bit v);
    memRdy  = v;
    rdyPrev = v;
  endtask

  // rdyMode: 0 ready high, 1 random ready, 2 ready low for the first six clocks
  task automatic runBurst(input logic [AW-1:0] a, input bit w, input logic [2:0] b,
                          input logic [WW-1:0] wt, input bit we, input int rdyMode,
                          input bit pokeBusy);
    logic [NB*DW-1:0] d;
    logic [AW-1:0] stepV;
    logic [AW-1:0] expAddr;
    int nb, wEff, idx, wc, cyc;
    bit fin, comp, expWe;
    for (int i = 0; i < NB; i++) d[i*DW +: DW] = $urandom;
    nb = effBeats(b);
    wEff = effWait(wt, we);
    stepV = w ? AW'(4) : AW'(2);
    idx = 0; cyc = 0; fin = 1'b0;
    reqAddr = a; reqData = d; reqWord = w; cfgBeats = b; cfgWait = wt; cfgUseWe = we;
    reqValid = 1'b1;
    if (rdyMode == 2) driveRdy(1'b0);
    tick();
    reqValid = 1'b0;
    wc = wEff;
    while (!fin) begin
      expAddr = a + AW'(idx) * stepV;
      expWe = we ? (wc == 0 && rdyPrev) : 1'b1;
      chk(memCsN == 1'b0, "R7 chip select low in burst", 64'(memCsN), 64'd0);
      chk(memWeN == expWe, "R8/R4/R5 write enable", 64'(memWeN), 64'(expWe));
      chk(memAddr == expAddr, "R6 address", 64'(memAddr), 64'(expAddr));
      chk(memData == d[idx*DW +: DW], "R6 data", 64'(memData), 64'(d[idx*DW +: DW]));
      chk(memWord == w && memHalf == !w, "R6 size qualifiers", {62'd0, memHalf, memWord}, {62'd0, !w, w});
      chk(memOeN == 1'b1, "R9 output enable high", 64'(memOeN), 64'd1);
      chk(done == 1'b0 && idle == 1'b0, "R2/R10 busy flags", {62'd0, idle, done}, 64'd0);
      comp = (wc == 0) && rdyPrev;
      if (pokeBusy && cyc == 1) begin
        reqValid = 1'b1;
        reqAddr = ~a;
      end else begin
        reqValid = 1'b0;
      end
      if (rdyMode == 1) driveRdy(($urandom % 10) < 7);
      else if (rdyMode == 2) driveRdy(cyc >= 5);
      else driveRdy(1'b1);
      if (comp) begin
        if (idx == nb - 1) fin = 1'b1;
        else begin
          idx++;
          wc = wEff;
        end
      end else if (wc > 0) begin
        wc--;
      end
      cyc++;
      if (cyc > 300) begin
        chk(1'b0, "R5 burst never ended", 64'(cyc), 64'd0);
        fin = 1'b1;
      end
      tick();
    end
    reqValid = 1'b0;
    driveRdy(1'b1);
    expAddr = a + AW'(nb - 1) * stepV;
    chk(done == 1'b1, "R10 done after last beat", 64'(done), 64'd1);
    chk(memCsN == 1'b1 && idle == 1'b1, "R7 chip select released", {62'd0, memCsN, idle}, 64'd3);
    chk(memAddr == expAddr, "R11 address held", 64'(memAddr), 64'(expAddr));
    tick();
    chk(done == 1'b0, "R10 done one clock", 64'(done), 64'd0);
    chk(memCsN == 1'b1, "R2 no burst from busy request", 64'(memCsN), 64'd1);
    chk(memAddr == expAddr && memData == d[(nb-1)*DW +: DW] && memWrite == 1'b1,
        "R11 outputs held", 64'(memAddr), 64'(expAddr));
    tick();
    chk(memCsN == 1'b1 && idle == 1'b1, "R2 stays idle", {62'd0, memCsN, idle}, 64'd3);
  endtask

  // count the clocks that chip select is low for one ready-high burst
  task automatic csLength(input logic [2:0] b, input logic [WW-1:0] wt, input bit we,
                          input int expLen, input string tag);
    int n = 0;
    reqAddr = AW'(24'h000100); reqWord = 1'b1; cfgBeats = b; cfgWait = wt; cfgUseWe = we;
    reqValid = 1'b1;
    tick();
    reqValid = 1'b0;
    while (memCsN == 1'b0 && n < 100) begin
      n++;
      tick();
    end
    chk(n == expLen, tag, 64'(n), 64'(expLen));
    tick();
  endtask

  initial begin
    void'($urandom(32'd2024));
    #3;
    chk(memCsN && memWeN && memOeN, "R1 strobes high in reset", {61'd0, memCsN, memWeN, memOeN}, 64'd7);
    chk(idle == 1'b1 && done == 1'b0 && memWrite == 1'b0, "R1 flags in reset",
        {61'd0, idle, done, memWrite}, 64'd4);
    repeat (3) tick();
    rstN = 1'b1;
    repeat (3) tick();
    chk(memCsN && memWeN && idle && !done, "R1 state after reset",
        {60'd0, memCsN, memWeN, idle, done}, 64'hE);

    // directed cases
    csLength(3'd4, 3'd0, 1'b0, 4, "R4 1-1-1-1 burst length");
    csLength(3'd4, 3'd0, 1'b1, 8, "R4 zero waits raised to one with write enable");
    csLength(3'd0, 3'd0, 1'b0, 2, "R3 count 0 clamped to 2");
    csLength(3'd1, 3'd1, 1'b0, 4, "R3 count 1 clamped to 2");
    csLength(3'd7, 3'd0, 1'b0, 4, "R3 count 7 clamped to 4");
    csLength(3'd3, 3'd2, 1'b1, 9, "R4 three beats of three clocks");
    runBurst(24'h00FFFE, 1'b0, 3'd4, 3'd0, 1'b0, 0, 1'b0);
    runBurst(24'h001000, 1'b1, 3'd4, 3'd1, 1'b1, 0, 1'b0);
    runBurst(24'h002000, 1'b1, 3'd2, 3'd0, 1'b1, 2, 1'b0); // R5 ready held low
    runBurst(24'h003000, 1'b0, 3'd2, 3'd0, 1'b0, 0, 1'b1); // R2 busy request
    runBurst(24'h004000, 1'b1, 3'd3, 3'd2, 1'b1, 1, 1'b1);

    // random bursts
    for (int k = 0; k < 60; k++) begin
      runBurst(AW'($urandom), 1'($urandom), 3'($urandom % 8), WW'($urandom % 4),
               1'($urandom), int'($urandom % 2), 1'($urandom));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule